// File: doc/BRIEF.md
# Converter Soft-Start and Fault Hiccup Sequencer

This block is the digital sequencer of a multi-phase buck controller. It counts switching cycles, supplied as a one-clock strobe per cycle, and from that count decides what the phase outputs may do. The three possibilities are high impedance, a forced-low clamp, or normal pulse-width modulation. It also produces a duty-cycle ceiling that climbs from zero during start-up, a reference-enable flag, and the release of an open-drain power-good line.

A start-up runs in three stages. The phase outputs first float for a fixed number of cycles. They are then clamped low for a programmable interval. Finally, modulation runs with a duty ceiling that climbs one LSB per cycle to full scale. A second counter times the power-good delay from the start of the sequence. If average current trips, the outputs float for a fixed wait, after which a new start-up is attempted, and this repeats while the fault persists. An overvoltage event locks the block into a protection loop. In that loop the outputs are clamped low while the output is high, and float once it has come back to target. Only a drop of the supply power-on-reset clears the lock. An undervoltage flag affects only power-good.

The analog comparators and the oscillator are outside the block. Output encoding for `pwm_mode`: 2'b00 high impedance, 2'b01 forced low, 2'b10 normal switching.

Top module: `ssq_hiccup_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, or while `por_good` is low at a clock edge, after that edge `pwm_mode` is 2'b00, `duty_lim` is 0, `ref_en` is 0 and `pgood_rel` is 0, and any overvoltage lock is cleared.
- R2: A start-up begins on the edge where `por_good`, `en_req` and `!vid_off` are all true. Outside the overvoltage lock, if `en_req` is low or `vid_off` is high at an edge, the block returns to the off state (outputs as in R1) after that edge.
- R3: For the first `HIZ_CYC` strobes of a start-up, `pwm_mode` is 2'b00, `ref_en` is 0 and `duty_lim` is 0.
- R4: For the next `CLAMP_CYC` strobes, `pwm_mode` is 2'b01, `ref_en` is 1 and `duty_lim` is 0.
- R5: After that, `pwm_mode` is 2'b10 and `duty_lim` starts at 0, rises by one per strobe until it is all ones, and then holds all ones.
- R6: `pgood_rel` is 1 only when at least `PG_CYC` strobes have passed since the start-up began, `pwm_mode` is 2'b10 and `uv_low` is 0.
- R7: `oc_trip` at an edge during any start-up stage or normal switching makes `pwm_mode` 2'b00, with `duty_lim` 0 and `pgood_rel` 0, for `HICCUP_CYC` strobes. A fresh start-up then follows, and this repeats while `oc_trip` stays high.
- R8: `ov_high` at an edge during the clamp, ramp or normal stage makes `pwm_mode` 2'b01 with `ref_en` 0. Afterwards, `ov_clear` (with `ov_high` low) makes it 2'b00, and each new `ov_high` makes it 2'b01 again.
- R9: Once locked by overvoltage, `en_req`, `vid_off` and `oc_trip` have no effect. Only `por_good` going low releases the lock, and a start-up follows when it returns high.
- R10: `ov_high` is ignored while off, in the first high-impedance stage of a start-up, and during the hiccup wait.
- R11: `uv_low` drops `pgood_rel` in the same cycle, changes nothing else, and leaves no effect after it goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_good | input | 1 | Supply power-on-reset is good |
| en_req | input | 1 | External enable |
| vid_off | input | 1 | Reserved off code seen on the voltage-ID inputs |
| cyc_tick | input | 1 | One-clock strobe at each switching-cycle start |
| oc_trip | input | 1 | Average current above trip level |
| ov_high | input | 1 | Output above the overvoltage threshold |
| ov_clear | input | 1 | Output back at or below target |
| uv_low | input | 1 | Output below the undervoltage margin |
| pwm_mode | output | 2 | Phase output mode: 00 float, 01 low, 10 switch |
| duty_lim | output | RAMP_W | Duty-cycle ceiling |
| ref_en | output | 1 | Reference DAC enabled |
| pgood_rel | output | 1 | 1 releases the open-drain power-good line |

## Verification
A wrong stage state appears on `pwm_mode`, `ref_en` or `duty_lim` one clock after the edge that should have moved it. This is easiest to see at the stage boundaries, where the mode code changes. A phase counter that is off by one shifts each of those boundaries by one strobe, so it shows up at the next boundary, at most a stage length later. An error in the power-good counter shows only on `pgood_rel`, at the `PG_CYC`-th strobe after start. A lost or spurious overvoltage lock shows on the first later change of `en_req` or `oc_trip`, which should then have no effect.

// File: rtl/ssq_pkg.sv
// Package: shared encodings for the soft-start sequencer.
// Assumes: the mode codes are decoded by the phase output stage as given here.
package ssq_pkg;

    typedef enum logic [1:0] {
        PWM_HIZ = 2'b00,
        PWM_LOW = 2'b01,
        PWM_RUN = 2'b10
    } pwm_mode_e;

    typedef enum logic [2:0] {
        SQ_OFF   = 3'd0,
        SQ_HIZ   = 3'd1,
        SQ_CLAMP = 3'd2,
        SQ_RAMP  = 3'd3,
        SQ_RUN   = 3'd4,
        SQ_OCW   = 3'd5,
        SQ_OVL   = 3'd6,
        SQ_OVH   = 3'd7
    } seq_st_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ssq_cycle_ctr.sv
// Module: strobe counter with synchronous clear.
// Does: counts inc pulses. SAT_AT > 0 selects a saturating variant that
// stops at SAT_AT; SAT_AT == 0 selects a wrapping variant.
// Assumes: clr has priority over inc.
module ssq_cycle_ctr #(
    parameter int W      = 8,
    parameter int SAT_AT = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    generate
        if (SAT_AT > 0) begin : g_sat
            // Saturating count, held at SAT_AT
            always_ff @(posedge clk) begin
                if (!rst_n)                            cnt <= '0;
                else if (clr)                          cnt <= '0;
                else if (inc && (cnt != W'(SAT_AT)))   cnt <= cnt + 1'b1;
            end
        end else begin : g_wrap
            // Free wrapping count
            always_ff @(posedge clk) begin
                if (!rst_n)      cnt <= '0;
                else if (clr)    cnt <= '0;
                else if (inc)    cnt <= cnt + 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/ssq_out_map.sv
// Module: output decode of the sequencer state.
// Does: maps stage state to phase mode, duty ceiling, reference enable and
// power-good release.
// Assumes: ramp_val is the strobe count inside the ramp stage.
module ssq_out_map
    import ssq_pkg::*;
#(
    parameter int RW = 8
) (
    input  seq_st_e       st,
    input  logic [RW-1:0] ramp_val,
    input  logic          pg_done,
    input  logic          uv_low,
    output logic [1:0]    pwm_mode,
    output logic [RW-1:0] duty_lim,
    output logic          ref_en,
    output logic          pgood_rel
);

    // Mode and reference enable per stage
    always_comb begin
        case (st)
            SQ_CLAMP: begin pwm_mode = PWM_LOW; ref_en = 1'b1; end
            SQ_RAMP:  begin pwm_mode = PWM_RUN; ref_en = 1'b1; end
            SQ_RUN:   begin pwm_mode = PWM_RUN; ref_en = 1'b1; end
            SQ_OVL:   begin pwm_mode = PWM_LOW; ref_en = 1'b0; end
            default:  begin pwm_mode = PWM_HIZ; ref_en = 1'b0; end
        endcase
    end

    // Duty ceiling: ramp value, full scale, or zero
    always_comb begin
        if (st == SQ_RAMP)     duty_lim = ramp_val;
        else if (st == SQ_RUN) duty_lim = '1;
        else                   duty_lim = '0;
    end

    // Power-good release: delay done, switching, no undervoltage
    always_comb begin
        pgood_rel = pg_done && !uv_low && ((st == SQ_RAMP) || (st == SQ_RUN));
    end

endmodule

// File: rtl/ssq_hiccup_seq.sv
// Module: soft-start and fault hiccup sequencer (top).
// Does: steps through float, clamp and ramp start-up stages, times the
// power-good delay, runs an overcurrent hiccup retry and an overvoltage lock
// that only a power-on-reset drop clears.
// Assumes: cyc_tick is a one-clock pulse per switching cycle; comparator
// flags are already synchronous to clk.
module ssq_hiccup_seq
    import ssq_pkg::*;
#(
    parameter int HIZ_CYC    = 32,
    parameter int CLAMP_CYC  = 150,
    parameter int RAMP_W     = 8,
    parameter int PG_CYC     = 2048,
    parameter int HICCUP_CYC = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_good,
    input  logic              en_req,
    input  logic              vid_off,
    input  logic              cyc_tick,
    input  logic              oc_trip,
    input  logic              ov_high,
    input  logic              ov_clear,
    input  logic              uv_low,
    output logic [1:0]        pwm_mode,
    output logic [RAMP_W-1:0] duty_lim,
    output logic              ref_en,
    output logic              pgood_rel
);

    localparam int RAMP_TOP = (1 << RAMP_W) - 1;
    localparam int PH_MAX   = imax(imax(HIZ_CYC, CLAMP_CYC), imax(HICCUP_CYC, RAMP_TOP));
    localparam int PH_W     = imax($clog2(PH_MAX + 1), RAMP_W);
    localparam int PG_W     = $clog2(PG_CYC + 1);

    seq_st_e          st, st_nx;
    logic [PH_W-1:0]  ph_cnt;
    logic [PG_W-1:0]  pg_cnt;
    logic             start_ok, ss_active, ov_watch;
    logic             hiz_end, clamp_end, ramp_end, wait_end;
    logic             pg_done;

    // Qualifiers for start and fault windows
    always_comb begin
        start_ok  = por_good && en_req && !vid_off;
        ss_active = (st == SQ_HIZ) || (st == SQ_CLAMP) || (st == SQ_RAMP) || (st == SQ_RUN);
        ov_watch  = (st == SQ_CLAMP) || (st == SQ_RAMP) || (st == SQ_RUN);
    end

    // Stage terminal counts, taken on the strobe
    always_comb begin
        hiz_end   = cyc_tick && (ph_cnt == PH_W'(HIZ_CYC - 1));
        clamp_end = cyc_tick && (ph_cnt == PH_W'(CLAMP_CYC - 1));
        ramp_end  = cyc_tick && (ph_cnt == PH_W'(RAMP_TOP - 1));
        wait_end  = cyc_tick && (ph_cnt == PH_W'(HICCUP_CYC - 1));
        pg_done   = (pg_cnt == PG_W'(PG_CYC));
    end

    // Next-state with priority: POR, OV lock, new OV, enable, OC, progression
    always_comb begin
        st_nx = st;
        if (!por_good) begin
            st_nx = SQ_OFF;
        end else if (st == SQ_OVL) begin
            if (ov_clear && !ov_high) st_nx = SQ_OVH;
        end else if (st == SQ_OVH) begin
            if (ov_high) st_nx = SQ_OVL;
        end else if (ov_high && ov_watch) begin
            st_nx = SQ_OVL;
        end else if (!start_ok) begin
            st_nx = SQ_OFF;
        end else if (oc_trip && ss_active) begin
            st_nx = SQ_OCW;
        end else begin
            case (st)
                SQ_OFF:   st_nx = SQ_HIZ;
                SQ_HIZ:   if (hiz_end)   st_nx = SQ_CLAMP;
                SQ_CLAMP: if (clamp_end) st_nx = SQ_RAMP;
                SQ_RAMP:  if (ramp_end)  st_nx = SQ_RUN;
                SQ_OCW:   if (wait_end)  st_nx = SQ_HIZ;
                default:  st_nx = st;
            endcase
        end
    end

    // Stage register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= SQ_OFF;
        else        st <= st_nx;
    end

    // Strobes spent in the current stage; restarts on every stage change
    ssq_cycle_ctr #(.W(PH_W), .SAT_AT(0)) u_phase_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (st_nx != st),
        .inc   (cyc_tick),
        .cnt   (ph_cnt)
    );

    // Strobes since start-up began, for the power-good delay
    ssq_cycle_ctr #(.W(PG_W), .SAT_AT(PG_CYC)) u_pg_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!ss_active),
        .inc   (cyc_tick),
        .cnt   (pg_cnt)
    );

    ssq_out_map #(.RW(RAMP_W)) u_out_map (
        .st        (st),
        .ramp_val  (ph_cnt[RAMP_W-1:0]),
        .pg_done   (pg_done),
        .uv_low    (uv_low),
        .pwm_mode  (pwm_mode),
        .duty_lim  (duty_lim),
        .ref_en    (ref_en),
        .pgood_rel (pgood_rel)
    );

endmodule

// File: rtl/ssq_hiccup_checker.sv
// Module: port-level property checker for the sequencer, bound to the top.
// Assumes: mode codes 00 float, 01 low, 10 switch.
module ssq_hiccup_checker #(
    parameter int RW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          por_good,
    input logic          en_req,
    input logic          vid_off,
    input logic          oc_trip,
    input logic          ov_high,
    input logic          ov_clear,
    input logic          uv_low,
    input logic [1:0]    pwm_mode,
    input logic [RW-1:0] duty_lim,
    input logic          ref_en,
    input logic          pgood_rel
);

    assert_por_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !por_good |=> (pwm_mode == 2'b00 && duty_lim == '0 && !ref_en && !pgood_rel));

    assert_float_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode == 2'b00) |-> (duty_lim == '0 && !pgood_rel));

    assert_ramp_rises_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode == 2'b10 && por_good && en_req && !vid_off && !oc_trip && !ov_high)
        |=> (pwm_mode == 2'b10 && duty_lim >= $past(duty_lim)));

    assert_pg_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pgood_rel |-> (pwm_mode == 2'b10 && ref_en && !uv_low));

    assert_oc_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode == 2'b10 && oc_trip && !ov_high && por_good && en_req && !vid_off)
        |=> (pwm_mode == 2'b00 && duty_lim == '0));

    assert_ov_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode == 2'b10 && ov_high && por_good) |=> (pwm_mode == 2'b01 && !ref_en));

    assert_ov_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode == 2'b01 && !ref_en && ov_clear && !ov_high && por_good) |=> (pwm_mode == 2'b00));

endmodule

bind ssq_hiccup_seq ssq_hiccup_checker #(.RW(RAMP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_good  (por_good),
    .en_req    (en_req),
    .vid_off   (vid_off),
    .oc_trip   (oc_trip),
    .ov_high   (ov_high),
    .ov_clear  (ov_clear),
    .uv_low    (uv_low),
    .pwm_mode  (pwm_mode),
    .duty_lim  (duty_lim),
    .ref_en    (ref_en),
    .pgood_rel (pgood_rel)
);

// File: tb/ssq_hiccup_seq_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference model of the sequencer, compared every clock.
module ssq_hiccup_seq_bench;

    localparam int HIZ_N   = 4;
    localparam int CLAMP_N = 6;
    localparam int RW      = 3;
    localparam int PG_N    = 40;
    localparam int WAIT_N  = 20;
    localparam int TOPV    = (1 << RW) - 1;

    // model stage numbers
    localparam int M_OFF = 0, M_HIZ = 1, M_CLAMP = 2, M_RAMP = 3, M_RUN = 4,
                   M_OCW = 5, M_OVL = 6, M_OVH = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por_good = 1'b1, en_req = 1'b0, vid_off = 1'b0, cyc_tick = 1'b0;
    logic oc_trip = 1'b0, ov_high = 1'b0, ov_clear = 1'b0, uv_low = 1'b0;
    logic [1:0]    pwm_mode;
    logic [RW-1:0] duty_lim;
    logic          ref_en, pgood_rel;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    int    tdiv     = 0;
    bit    armed    = 1'b0;
    bit    done     = 1'b0;
    string scen     = "R1";

    int m_st = M_OFF;
    int m_ph = 0;
    int m_pg = 0;

    always #10 clk = ~clk;

    ssq_hiccup_seq #(
        .HIZ_CYC(HIZ_N), .CLAMP_CYC(CLAMP_N), .RAMP_W(RW),
        .PG_CYC(PG_N), .HICCUP_CYC(WAIT_N)
    ) u_ssq_hiccup_seq (
        .clk(clk), .rst_n(rst_n), .por_good(por_good), .en_req(en_req),
        .vid_off(vid_off), .cyc_tick(cyc_tick), .oc_trip(oc_trip),
        .ov_high(ov_high), .ov_clear(ov_clear), .uv_low(uv_low),
        .pwm_mode(pwm_mode), .duty_lim(duty_lim), .ref_en(ref_en),
        .pgood_rel(pgood_rel)
    );

    // Strobe every third clock
    always @(negedge clk) begin
        tdiv     = (tdiv + 1) % 3;
        cyc_tick <= (tdiv == 0);
    end

    // Reference model, advanced on each rising edge
    always @(posedge clk) begin
        int nx;
        bit tk;
        bool_blk: begin end
        armed = 1'b1;
        tk = cyc_tick;
        if (!rst_n) begin
            m_st = M_OFF; m_ph = 0; m_pg = 0;
        end else begin
            nx = m_st;
            if (!por_good) nx = M_OFF;
            else if (m_st == M_OVL) begin if (ov_clear && !ov_high) nx = M_OVH; end
            else if (m_st == M_OVH) begin if (ov_high) nx = M_OVL; end
            else if (ov_high && (m_st == M_CLAMP || m_st == M_RAMP || m_st == M_RUN)) nx = M_OVL;
            else if (!en_req || vid_off) nx = M_OFF;
            else if (oc_trip && m_st >= M_HIZ && m_st <= M_RUN) nx = M_OCW;
            else if (m_st == M_OFF) nx = M_HIZ;
            else if (m_st == M_HIZ   && tk && m_ph == HIZ_N - 1)   nx = M_CLAMP;
            else if (m_st == M_CLAMP && tk && m_ph == CLAMP_N - 1) nx = M_RAMP;
            else if (m_st == M_RAMP  && tk && m_ph == TOPV - 1)    nx = M_RUN;
            else if (m_st == M_OCW   && tk && m_ph == WAIT_N - 1)  nx = M_HIZ;
            if (!(m_st >= M_HIZ && m_st <= M_RUN)) m_pg = 0;
            else if (tk && m_pg < PG_N) m_pg++;
            if (nx != m_st) m_ph = 0;
            else if (tk) m_ph++;
            m_st = nx;
        end
    end

    function automatic string st_tag(input int s, input bit pg_field);
        if (s == M_OFF)   return "R2";
        if (s == M_HIZ)   return "R3";
        if (s == M_CLAMP) return "R4";
        if (s == M_OCW)   return "R7";
        if (s >= M_OVL)   return "R8";
        return pg_field ? "R6" : "R5";
    endfunction

    task automatic cmp_field(input string nm, input int act, input int exp, input bit pgf);
        string tg;
        n_checks++;
        if (act !== exp) begin
            tg = (scen != "") ? scen : st_tag(m_st, pgf);
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tg, nm, cycles, act, exp);
        end
    endtask

    // Compare outputs against the model away from the rising edge
    always @(negedge clk) begin
        int e_mode, e_duty, e_ref, e_pg;
        cycles++;
        #1;
        if (armed && !done) begin
            case (m_st)
                M_CLAMP, M_OVL: e_mode = 1;
                M_RAMP, M_RUN:  e_mode = 2;
                default:        e_mode = 0;
            endcase
            e_duty = (m_st == M_RAMP) ? m_ph : ((m_st == M_RUN) ? TOPV : 0);
            e_ref  = (m_st >= M_CLAMP && m_st <= M_RUN) ? 1 : 0;
            e_pg   = ((m_st == M_RAMP || m_st == M_RUN) && m_pg == PG_N && !uv_low) ? 1 : 0;
            cmp_field("pwm_mode",  int'(pwm_mode),  e_mode, 1'b0);
            cmp_field("duty_lim",  int'(duty_lim),  e_duty, 1'b0);
            cmp_field("ref_en",    int'(ref_en),    e_ref,  1'b0);
            cmp_field("pgood_rel", int'(pgood_rel), e_pg,   1'b1);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d: actual hung expected finish", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(5);
        // R2: enable with reserved off code must not start
        scen = "R2"; en_req = 1'b1; vid_off = 1'b1;
        wait_clk(10);
        vid_off = 1'b0; scen = "";
        wait_clk(160);                          // R3, R4, R5, R6 by stage
        // R11: undervoltage only drops power-good
        scen = "R11"; uv_low = 1'b1;
        wait_clk(6);
        uv_low = 1'b0;
        wait_clk(6);
        // R2: enable drop returns to off, then restart
        scen = "R2"; en_req = 1'b0;
        wait_clk(4);
        en_req = 1'b1; scen = "";
        wait_clk(160);
        // R7: single trip, then persistent trip
        scen = "R7"; oc_trip = 1'b1;
        wait_clk(1);
        oc_trip = 1'b0;
        wait_clk(100);
        oc_trip = 1'b1;
        wait_clk(150);
        oc_trip = 1'b0; scen = "";
        wait_clk(160);
        // R10: overvoltage during first float stage is ignored
        en_req = 1'b0;
        wait_clk(2);
        en_req = 1'b1;
        wait_clk(1);
        scen = "R10"; ov_high = 1'b1;
        wait_clk(6);
        ov_high = 1'b0; scen = "";
        wait_clk(160);
        // R8: clamp, release, re-clamp
        scen = "R8"; ov_high = 1'b1;
        wait_clk(2);
        ov_high = 1'b0;
        wait_clk(5);
        ov_clear = 1'b1;
        wait_clk(2);
        ov_clear = 1'b0;
        wait_clk(5);
        ov_high = 1'b1;
        wait_clk(2);
        ov_high = 1'b0; ov_clear = 1'b1;
        wait_clk(2);
        ov_clear = 1'b0;
        // R9: lock survives enable, code and overcurrent changes
        scen = "R9"; en_req = 1'b0;
        wait_clk(5);
        en_req = 1'b1; oc_trip = 1'b1;
        wait_clk(5);
        oc_trip = 1'b0; vid_off = 1'b1;
        wait_clk(5);
        vid_off = 1'b0;
        wait_clk(20);
        // R1: power-on-reset drop clears the lock
        scen = "R1"; por_good = 1'b0;
        wait_clk(3);
        por_good = 1'b1; scen = "R9";
        wait_clk(160);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule